// File: doc/BRIEF.md
# Word FIFO Byte-Stream Data Engine

This block sits between a host that moves 32-bit words and a card that moves one byte at a time. A sixteen-entry word FIFO holds the data in flight. In receive transfers the engine takes bytes from the card port, packs them into words with the first byte in the least significant lane, and pushes each word into the FIFO for the host to pop. In transmit transfers the host pushes words, and the engine pops them and sends the bytes out low byte first.

A transfer starts with a one-cycle start pulse that captures the direction and loads a byte counter from the length input. The counter counts down once for each byte that crosses the card port. When it reaches zero the transfer is marked finished. The engine stays active until the host has emptied the FIFO, and then it returns to idle by itself. FIFO occupancy flags are reported only for the side that matches the current direction, and all of them are held low while the engine is idle.

The controller has five named states:
- idle (`ENG_IDLE`);
- receive-run (`ENG_RX_RUN`);
- transmit-fetch (`ENG_TX_FETCH`);
- transmit-send (`ENG_TX_SEND`);
- drain (`ENG_DRAIN`).

The transitions are as follows:
- A start pulse moves any state to receive-run or to transmit-fetch, depending on the direction.
- Receive-run moves to drain when the counter is zero or the last byte is accepted.
- Transmit-fetch moves to transmit-send when it pops a word, or to drain when the counter is zero.
- Transmit-send returns to transmit-fetch after the fourth byte of a word. It moves to drain after the last byte of the transfer.
- Drain moves to idle when the FIFO is empty.

Top module: `fifo_byte_engine`

## Requirements
- R1: The FIFO holds 16 words of 32 bits and returns them in the order they were pushed, with both pointers wrapping. A push to a full FIFO is dropped. `host_rdata` shows the oldest word, or zero when the FIFO is empty. A pop from an empty FIFO changes nothing.
- R2: A start pulse loads `byte_count` from `xfer_len` and captures `xfer_dir_rx` (1 = receive). It clears `data_end` and `block_end`. It raises `eng_active` on the next clock edge, and this also applies while a transfer is already running.
- R3: In a receive transfer, byte k of every group of four bytes lands in word bits 8k+7:8k.
- R4: In a receive transfer, a final word holding fewer than four bytes is pushed with its unused upper bytes set to zero.
- R5: In a transmit transfer, each popped word is sent on `card_tx_data` as bits 7:0 first, then bits 15:8, then 23:16, then 31:24.
- R6: `byte_count` drops by one for every byte accepted on the card port. `word_count` always equals (`byte_count` + 3) >> 2.
- R7: When `byte_count` reaches zero, `data_end` and `block_end` go high. When the count is zero and the FIFO is empty, `eng_active` falls.
- R8: Occupancy flags follow fixed rules. Empty means 0 words and avail means 1 or more. Full means 16 words. `tx_half_empty` means 8 or fewer words, and `rx_half_full` means 8 or more.
- R9: While active, only the `rx_*` flags are driven in receive direction and only the `tx_*` flags in transmit direction. The `*_active` flag of that side is high. In idle, all flags are low.
- R10: `card_rx_ready` is low whenever the FIFO is full or the count is zero. `card_tx_valid` is low while the FIFO is empty and no bytes of the current word remain.
- R11: A host push is ignored in receive-run, and a host pop is ignored in transmit-fetch and transmit-send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | One-cycle pulse that starts a transfer |
| xfer_dir_rx | input | 1 | 1 = receive from card, 0 = transmit to card |
| xfer_len | input | 16 | Transfer length in bytes |
| host_push | input | 1 | Host word push |
| host_wdata | input | 32 | Word to push |
| host_pop | input | 1 | Host word pop |
| host_rdata | output | 32 | Oldest FIFO word, zero when empty |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_data | input | 8 | Byte from card |
| card_rx_ready | output | 1 | Engine accepts a card byte |
| card_tx_valid | output | 1 | Engine offers a byte to the card |
| card_tx_data | output | 8 | Byte to card |
| card_tx_ready | input | 1 | Card accepts the byte |
| eng_active | output | 1 | Engine enable, cleared by the engine itself |
| byte_count | output | 16 | Bytes still to transfer |
| word_count | output | 16 | Words still to transfer, rounded up |
| data_end | output | 1 | Count reached zero |
| block_end | output | 1 | Block finished (follows data_end) |
| rx_active | output | 1 | Receive flags valid |
| rx_empty | output | 1 | Receive side, FIFO empty |
| rx_avail | output | 1 | Receive side, data available |
| rx_full | output | 1 | Receive side, FIFO full |
| rx_half_full | output | 1 | Receive side, occupancy at least 8 |
| tx_active | output | 1 | Transmit flags valid |
| tx_empty | output | 1 | Transmit side, FIFO empty |
| tx_avail | output | 1 | Transmit side, data available |
| tx_full | output | 1 | Transmit side, FIFO full |
| tx_half_empty | output | 1 | Transmit side, occupancy at most 8 |

## Verification
A broken packing lane or pointer shows up in the word popped by the host, at the latest when the last word of the transfer is read out. A counter that drifts by one shows up on `byte_count` and `word_count` in the cycle after the byte that caused it. The same drift also moves the edge at which `data_end` rises and `eng_active` falls, by one cycle. An occupancy error cannot be read directly. It appears on the half, full and empty flags at the 0, 8 and 16 word boundaries, so the bench sweeps every occupancy from 16 down to 0 in both directions.

// File: rtl/fbe_pkg.sv
`timescale 1ns/1ps
package fbe_pkg;

    typedef enum logic [2:0] {
        ENG_IDLE     = 3'd0,
        ENG_RX_RUN   = 3'd1,
        ENG_TX_FETCH = 3'd2,
        ENG_TX_SEND  = 3'd3,
        ENG_DRAIN    = 3'd4
    } eng_state_t;

    typedef struct packed {
        logic act;
        logic half;
        logic full;
        logic empty;
        logic avail;
    } side_flags_t;

endpackage

// File: rtl/fbe_word_fifo.sv
`timescale 1ns/1ps
module fbe_word_fifo #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic                       rd_en,
    output logic [WORD_W-1:0]          rd_data,
    output logic [$clog2(DEPTH):0]     occ,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic              do_wr;
    logic              do_rd;

    assign full  = (occ == CW'(DEPTH));
    assign empty = (occ == '0);
    assign do_wr = wr_en && !full;
    assign do_rd = rd_en && !empty;
    assign rd_data = empty ? '0 : mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (do_wr) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            unique case ({do_wr, do_rd})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && full && !rd_en) |=> (occ == CW'(DEPTH))); // R1
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && empty && !wr_en) |=> (occ == '0)); // R1
    AST_OCC_RANGE: assert property (@(posedge clk) disable iff (!rst_n) occ <= CW'(DEPTH)); // R1

endmodule

// File: rtl/fbe_side_flags.sv
`timescale 1ns/1ps
module fbe_side_flags
    import fbe_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic [$clog2(DEPTH):0] occ,
    input  logic                   active,
    input  logic                   dir_rx,
    output side_flags_t            rx_flags,
    output side_flags_t            tx_flags
);
    localparam int CW   = $clog2(DEPTH) + 1;
    localparam int HALF = DEPTH / 2;

    for (genvar s = 0; s < 2; s++) begin : g_side
        localparam bit IS_RX = (s == 0);
        logic        on;
        side_flags_t f;

        assign on      = active && (dir_rx == IS_RX);
        assign f.act   = on;
        assign f.empty = on && (occ == '0);
        assign f.avail = on && (occ != '0);
        assign f.full  = on && (occ == CW'(DEPTH));
        if (IS_RX) begin : g_rx
            assign f.half  = on && (occ >= CW'(HALF));
            assign rx_flags = f;
        end else begin : g_tx
            assign f.half  = on && (occ <= CW'(HALF));
            assign tx_flags = f;
        end
    end

endmodule

// File: rtl/fbe_ctrl.sv
`timescale 1ns/1ps
module fbe_ctrl
    import fbe_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_rx,
    input  logic [LEN_W-1:0]  len,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_head,
    output logic              eng_push,
    output logic [WORD_W-1:0] eng_word,
    output logic              eng_pop,
    output logic              active,
    output logic              dir_q,
    output logic              rx_run,
    output logic              tx_run,
    output logic [LEN_W-1:0]  cnt,
    output logic              end_q
);
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LANE_W = $clog2(LANES);
    localparam int LEFT_W = $clog2(LANES + 1);

    eng_state_t         state;
    eng_state_t         state_nx;
    logic [BYTE_W-1:0]  acc [LANES];
    logic [LANE_W-1:0]  lane;
    logic [WORD_W-1:0]  txw;
    logic [LEFT_W-1:0]  left;
    logic               rx_go;
    logic               tx_go;
    logic               cnt_zero;
    logic               cnt_last;

    assign cnt_zero = (cnt == '0);
    assign cnt_last = (cnt == LEN_W'(1));

    // next-state logic
    always_comb begin
        state_nx = state;
        if (start) begin
            state_nx = dir_rx ? ENG_RX_RUN : ENG_TX_FETCH;
        end else begin
            unique case (state)
                ENG_IDLE: state_nx = ENG_IDLE;
                ENG_RX_RUN: begin
                    if (cnt_zero || (rx_go && cnt_last)) state_nx = ENG_DRAIN;
                end
                ENG_TX_FETCH: begin
                    if (cnt_zero)        state_nx = ENG_DRAIN;
                    else if (!fifo_empty) state_nx = ENG_TX_SEND;
                end
                ENG_TX_SEND: begin
                    if (tx_go) begin
                        if (cnt_last)                   state_nx = ENG_DRAIN;
                        else if (left == LEFT_W'(1))    state_nx = ENG_TX_FETCH;
                    end
                end
                ENG_DRAIN: begin
                    if (fifo_empty) state_nx = ENG_IDLE;
                end
                default: state_nx = ENG_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ENG_IDLE;
        else        state <= state_nx;
    end

    // outputs decoded from state
    always_comb begin
        active   = (state != ENG_IDLE);
        rx_run   = (state == ENG_RX_RUN);
        tx_run   = (state == ENG_TX_FETCH) || (state == ENG_TX_SEND);
        rx_ready = rx_run && !cnt_zero && !fifo_full;
        rx_go    = rx_ready && rx_valid;
        eng_push = rx_go && ((lane == LANE_W'(LANES - 1)) || cnt_last);
        eng_pop  = (state == ENG_TX_FETCH) && !cnt_zero && !fifo_empty;
        tx_valid = (state == ENG_TX_SEND);
        tx_data  = txw[BYTE_W-1:0];
        tx_go    = tx_valid && tx_ready;
        for (int k = 0; k < LANES; k++) begin
            if (k < int'(lane))       eng_word[k*BYTE_W +: BYTE_W] = acc[k];
            else if (k == int'(lane)) eng_word[k*BYTE_W +: BYTE_W] = rx_data;
            else                      eng_word[k*BYTE_W +: BYTE_W] = '0;
        end
    end

    // datapath: counter, packing lanes, transmit shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            dir_q <= 1'b0;
            lane  <= '0;
            txw   <= '0;
            left  <= '0;
            end_q <= 1'b0;
            for (int k = 0; k < LANES; k++) acc[k] <= '0;
        end else if (start) begin
            cnt   <= len;
            dir_q <= dir_rx;
            lane  <= '0;
            left  <= '0;
            end_q <= 1'b0;
        end else begin
            if (rx_go) begin
                cnt <= cnt - 1'b1;
                if (eng_push) begin
                    lane <= '0;
                end else begin
                    acc[lane] <= rx_data;
                    lane      <= lane + 1'b1;
                end
            end
            if (eng_pop) begin
                txw  <= fifo_head;
                left <= LEFT_W'(LANES);
            end
            if (tx_go) begin
                txw  <= txw >> BYTE_W;
                left <= left - 1'b1;
                cnt  <= cnt - 1'b1;
            end
            if ((state != ENG_DRAIN) && (state_nx == ENG_DRAIN)) end_q <= 1'b1;
        end
    end

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n) start |=> (cnt == $past(len) && active)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) ((rx_go || tx_go) && !start) |=> (cnt == $past(cnt) - 1'b1)); // R6
    AST_TX_HAS_COUNT: assert property (@(posedge clk) disable iff (!rst_n) tx_valid |-> !cnt_zero); // R6
    AST_END_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n) (state == ENG_DRAIN) |-> (end_q && cnt_zero)); // R7
    AST_RX_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n) rx_ready |-> !fifo_full); // R10

endmodule

// File: rtl/fifo_byte_engine.sv
`timescale 1ns/1ps
module fifo_byte_engine
    import fbe_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              xfer_dir_rx,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              host_push,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              host_pop,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              card_rx_valid,
    input  logic [BYTE_W-1:0] card_rx_data,
    output logic              card_rx_ready,
    output logic              card_tx_valid,
    output logic [BYTE_W-1:0] card_tx_data,
    input  logic              card_tx_ready,
    output logic              eng_active,
    output logic [LEN_W-1:0]  byte_count,
    output logic [LEN_W-1:0]  word_count,
    output logic              data_end,
    output logic              block_end,
    output logic              rx_active,
    output logic              rx_empty,
    output logic              rx_avail,
    output logic              rx_full,
    output logic              rx_half_full,
    output logic              tx_active,
    output logic              tx_empty,
    output logic              tx_avail,
    output logic              tx_full,
    output logic              tx_half_empty
);
    localparam int CW     = $clog2(DEPTH) + 1;
    localparam int LANE_W = $clog2(WORD_W / BYTE_W);
    localparam int LANES  = WORD_W / BYTE_W;

    logic              fifo_wr;
    logic [WORD_W-1:0] fifo_wdata;
    logic              fifo_rd;
    logic [WORD_W-1:0] fifo_head;
    logic [CW-1:0]     fifo_occ;
    logic              fifo_full;
    logic              fifo_empty;
    logic              eng_push;
    logic [WORD_W-1:0] eng_word;
    logic              eng_pop;
    logic              dir_q;
    logic              rx_run;
    logic              tx_run;
    logic              end_q;
    logic [LEN_W:0]    wc_sum;
    side_flags_t       rx_f;
    side_flags_t       tx_f;

    // the engine owns the write side in receive-run, the read side while transmitting
    assign fifo_wr    = eng_push || (host_push && !rx_run);
    assign fifo_wdata = eng_push ? eng_word : host_wdata;
    assign fifo_rd    = eng_pop || (host_pop && !tx_run);
    assign host_rdata = fifo_head;

    fbe_word_fifo #(
        .DEPTH  (DEPTH),
        .WORD_W (WORD_W)
    ) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fifo_wr),
        .wr_data (fifo_wdata),
        .rd_en   (fifo_rd),
        .rd_data (fifo_head),
        .occ     (fifo_occ),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    fbe_ctrl #(
        .LEN_W  (LEN_W),
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (xfer_start),
        .dir_rx     (xfer_dir_rx),
        .len        (xfer_len),
        .rx_valid   (card_rx_valid),
        .rx_data    (card_rx_data),
        .rx_ready   (card_rx_ready),
        .tx_valid   (card_tx_valid),
        .tx_data    (card_tx_data),
        .tx_ready   (card_tx_ready),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .fifo_head  (fifo_head),
        .eng_push   (eng_push),
        .eng_word   (eng_word),
        .eng_pop    (eng_pop),
        .active     (eng_active),
        .dir_q      (dir_q),
        .rx_run     (rx_run),
        .tx_run     (tx_run),
        .cnt        (byte_count),
        .end_q      (end_q)
    );

    fbe_side_flags #(
        .DEPTH (DEPTH)
    ) flags_i (
        .occ      (fifo_occ),
        .active   (eng_active),
        .dir_rx   (dir_q),
        .rx_flags (rx_f),
        .tx_flags (tx_f)
    );

    assign wc_sum     = {1'b0, byte_count} + (LEN_W+1)'(LANES - 1);
    assign word_count = LEN_W'(wc_sum >> LANE_W);
    assign data_end   = end_q;
    assign block_end  = end_q;

    assign rx_active     = rx_f.act;
    assign rx_empty      = rx_f.empty;
    assign rx_avail      = rx_f.avail;
    assign rx_full       = rx_f.full;
    assign rx_half_full  = rx_f.half;
    assign tx_active     = tx_f.act;
    assign tx_empty      = tx_f.empty;
    assign tx_avail      = tx_f.avail;
    assign tx_full       = tx_f.full;
    assign tx_half_empty = tx_f.half;

    AST_ONE_SIDE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) !((|rx_f) && (|tx_f))); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !eng_active |-> (rx_f == '0 && tx_f == '0)); // R9
    AST_TX_STALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (card_tx_valid && !card_tx_ready) |=> card_tx_valid || xfer_start || $past(xfer_start)); // R10
    AST_RX_HOST_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) (rx_run && host_push && !eng_push && !fifo_rd) |=> (fifo_occ == $past(fifo_occ))); // R11

endmodule

// File: tb/fifo_byte_engine_tb.sv
`timescale 1ns/1ps
module fifo_byte_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0;
    logic        xfer_dir_rx = 1'b0;
    logic [15:0] xfer_len = '0;
    logic        host_push = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        host_pop = 1'b0;
    logic [31:0] host_rdata;
    logic        card_rx_valid = 1'b0;
    logic [7:0]  card_rx_data = '0;
    logic        card_rx_ready;
    logic        card_tx_valid;
    logic [7:0]  card_tx_data;
    logic        card_tx_ready = 1'b0;
    logic        eng_active;
    logic [15:0] byte_count;
    logic [15:0] word_count;
    logic        data_end;
    logic        block_end;
    logic        rx_active, rx_empty, rx_avail, rx_full, rx_half_full;
    logic        tx_active, tx_empty, tx_avail, tx_full, tx_half_empty;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fifo_byte_engine dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .xfer_start    (xfer_start),
        .xfer_dir_rx   (xfer_dir_rx),
        .xfer_len      (xfer_len),
        .host_push     (host_push),
        .host_wdata    (host_wdata),
        .host_pop      (host_pop),
        .host_rdata    (host_rdata),
        .card_rx_valid (card_rx_valid),
        .card_rx_data  (card_rx_data),
        .card_rx_ready (card_rx_ready),
        .card_tx_valid (card_tx_valid),
        .card_tx_data  (card_tx_data),
        .card_tx_ready (card_tx_ready),
        .eng_active    (eng_active),
        .byte_count    (byte_count),
        .word_count    (word_count),
        .data_end      (data_end),
        .block_end     (block_end),
        .rx_active     (rx_active),
        .rx_empty      (rx_empty),
        .rx_avail      (rx_avail),
        .rx_full       (rx_full),
        .rx_half_full  (rx_half_full),
        .tx_active     (tx_active),
        .tx_empty      (tx_empty),
        .tx_avail      (tx_avail),
        .tx_full       (tx_full),
        .tx_half_empty (tx_half_empty)
    );

    function automatic logic [4:0] rx_vec();
        return {rx_active, rx_half_full, rx_full, rx_empty, rx_avail};
    endfunction

    function automatic logic [4:0] tx_vec();
        return {tx_active, tx_half_empty, tx_full, tx_empty, tx_avail};
    endfunction

    // {act, half, full, empty, avail}
    function automatic logic [4:0] exp_fl(input int occ, input bit rxside);
        logic half;
        half = rxside ? (occ >= 8) : (occ <= 8);
        return {1'b1, half, occ == 16, occ == 0, occ != 0};
    endfunction

    function automatic logic [7:0] rx_byte(input int key, input int i);
        return 8'((key * 37) + (i * 11) + 5);
    endfunction

    function automatic logic [31:0] tx_word(input int key, input int w);
        return 32'((key * 32'h0101_0101) ^ (w * 32'h1357_9BDF) ^ 32'hC0DE_0000);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_w(input logic [31:0] d);
        host_push  = 1'b1;
        host_wdata = d;
        tick();
        host_push  = 1'b0;
    endtask

    task automatic pop_chk(input string req, input logic [31:0] exp);
        chk(req, host_rdata, exp);
        host_pop = 1'b1;
        tick();
        host_pop = 1'b0;
    endtask

    task automatic start_x(input bit dir, input int len);
        xfer_dir_rx = dir;
        xfer_len    = 16'(len);
        xfer_start  = 1'b1;
        tick();
        xfer_start  = 1'b0;
    endtask

    // feed card bytes [first,last) of a transfer with total length total
    task automatic rx_feed(input int key, input int total, input int first, input int last, input int gapmod);
        int i;
        i = first;
        for (int g = 0; g < 4000 && i < last; g++) begin
            bit took;
            card_rx_valid = (gapmod == 0) ? 1'b1 : ((g % gapmod) != (gapmod - 1));
            card_rx_data  = rx_byte(key, i);
            took = card_rx_valid && card_rx_ready;
            tick();
            if (took) begin
                i++;
                chk("R6 byte_count after rx byte", 32'(byte_count), 32'(total - i));
                chk("R6 word_count after rx byte", 32'(word_count), 32'((total - i + 3) >> 2));
            end
        end
        card_rx_valid = 1'b0;
        chk("R10 rx feed progress", 32'(i), 32'(last));
    endtask

    // collect card bytes [first,last); byte i comes from word w_base + i/4 of key
    task automatic tx_collect(input int key, input int total, input int first, input int last, input int rmod);
        int i;
        i = first;
        for (int g = 0; g < 4000 && i < last; g++) begin
            bit took;
            logic [7:0] got;
            logic [31:0] w;
            card_tx_ready = (rmod == 0) ? 1'b1 : ((g % rmod) != 1);
            took = card_tx_valid && card_tx_ready;
            got  = card_tx_data;
            tick();
            if (took) begin
                w = tx_word(key, i / 4);
                chk("R5 tx byte order", 32'(got), 32'(w >> (8 * (i % 4))) & 32'hFF);
                i++;
                chk("R6 byte_count after tx byte", 32'(byte_count), 32'(total - i));
            end
        end
        card_tx_ready = 1'b0;
        chk("R10 tx collect progress", 32'(i), 32'(last));
    endtask

    task automatic rx_pop_words(input int key, input int total, input int w0, input int w1);
        for (int w = w0; w < w1; w++) begin
            logic [31:0] e;
            e = '0;
            for (int b = 0; b < 4; b++) begin
                if ((4 * w + b) < total) e[8*b +: 8] = rx_byte(key, 4 * w + b);
            end
            pop_chk(((4 * w + 3) < total) ? "R3 rx packed word" : "R4 rx partial word", e);
        end
    endtask

    task automatic run_all();
        // reset
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R2 reset eng_active", 32'(eng_active), 0);
        chk("R6 reset byte_count", 32'(byte_count), 0);
        chk("R6 reset word_count", 32'(word_count), 0);
        chk("R7 reset data_end", 32'({data_end, block_end}), 0);
        chk("R1 reset host_rdata", host_rdata, 0);
        chk("R9 reset flags", 32'({rx_vec(), tx_vec()}), 0);
        chk("R10 reset handshakes", 32'({card_rx_ready, card_tx_valid}), 0);

        // occupancy sweep in both directions, zero-length transfers
        for (int d = 1; d >= 0; d--) begin
            for (int j = 0; j < 16; j++) push_w(32'h1000_0000 + 32'(d * 256 + j));
            push_w(32'hDEAD_BEEF);
            chk("R9 idle flags with full FIFO", 32'({rx_vec(), tx_vec()}), 0);
            start_x(d[0], 0);
            tick();
            chk("R7 zero length ends", 32'({data_end, block_end}), 32'h3);
            chk("R7 active while FIFO holds data", 32'(eng_active), 1);
            for (int k = 16; k >= 1; k--) begin
                if (d == 1) begin
                    chk("R8 rx flags at occupancy", 32'(rx_vec()), 32'(exp_fl(k, 1'b1)));
                    chk("R9 tx flags silent in rx", 32'(tx_vec()), 0);
                end else begin
                    chk("R8 tx flags at occupancy", 32'(tx_vec()), 32'(exp_fl(k, 1'b0)));
                    chk("R9 rx flags silent in tx", 32'(rx_vec()), 0);
                end
                pop_chk("R1 FIFO order", 32'h1000_0000 + 32'(d * 256 + 16 - k));
            end
            chk("R8 flags at occupancy 0", 32'(d == 1 ? rx_vec() : tx_vec()), 32'(exp_fl(0, d[0])));
            tick();
            chk("R7 engine idles when empty", 32'(eng_active), 0);
            chk("R9 idle flags", 32'({rx_vec(), tx_vec()}), 0);
            pop_chk("R1 empty pop returns zero", 32'h0);
            chk("R1 empty pop keeps zero", host_rdata, 0);
        end

        // receive length sweep
        for (int L = 1; L <= 20; L++) begin
            start_x(1'b1, L);
            chk("R2 start loads count", 32'(byte_count), 32'(L));
            chk("R2 start raises active", 32'(eng_active), 1);
            chk("R2 start clears end", 32'(data_end), 0);
            rx_feed(L, L, 0, L, (L % 4) + 2);
            chk("R7 rx data_end/block_end", 32'({data_end, block_end}), 32'h3);
            rx_pop_words(L, L, 0, (L + 3) / 4);
            tick();
            chk("R7 rx engine idle", 32'(eng_active), 0);
        end

        // transmit length sweep
        for (int L = 1; L <= 20; L++) begin
            for (int w = 0; w < (L + 3) / 4; w++) push_w(tx_word(L, w));
            start_x(1'b0, L);
            chk("R2 tx start loads count", 32'(byte_count), 32'(L));
            tx_collect(L, L, 0, L, (L % 3) + 2);
            chk("R7 tx data_end/block_end", 32'({data_end, block_end}), 32'h3);
            tick();
            chk("R7 tx engine idle", 32'(eng_active), 0);
        end

        // restart while receiving
        start_x(1'b1, 10);
        rx_feed(10, 10, 0, 2, 0);
        start_x(1'b1, 5);
        chk("R2 restart reloads count", 32'(byte_count), 5);
        rx_feed(5, 5, 0, 5, 0);
        rx_pop_words(5, 5, 0, 2);
        tick();
        chk("R2 restart ends idle", 32'(eng_active), 0);

        // receive stall on full FIFO and blocked host push
        start_x(1'b1, 70);
        rx_feed(70, 70, 0, 28, 0);
        push_w(32'h7777_7777);
        chk("R11 host push ignored in rx", 32'({rx_half_full, rx_avail}), 32'h1);
        rx_feed(70, 70, 28, 64, 0);
        card_rx_valid = 1'b1;
        card_rx_data  = rx_byte(70, 64);
        chk("R10 rx ready low when full", 32'(card_rx_ready), 0);
        chk("R8 rx full flag", 32'(rx_full), 1);
        repeat (3) tick();
        chk("R10 rx stalled count", 32'(byte_count), 6);
        card_rx_valid = 1'b0;
        rx_pop_words(70, 70, 0, 16);
        rx_feed(70, 70, 64, 70, 0);
        chk("R7 long rx end", 32'(data_end), 1);
        rx_pop_words(70, 70, 16, 18);
        tick();
        chk("R7 long rx idle", 32'(eng_active), 0);

        // transmit stall on empty FIFO and blocked host pop
        push_w(tx_word(99, 0));
        start_x(1'b0, 8);
        tx_collect(99, 8, 0, 4, 0);
        for (int c = 0; c < 3; c++) begin
            chk("R10 tx valid low when starved", 32'(card_tx_valid), 0);
            chk("R8 tx empty when starved", 32'(tx_empty), 1);
            tick();
        end
        chk("R10 tx starved count", 32'(byte_count), 4);
        push_w(tx_word(99, 1));
        push_w(tx_word(99, 2));
        host_pop = 1'b1;
        tick();
        host_pop = 1'b0;
        chk("R11 host pop ignored in tx", 32'({tx_avail, tx_empty}), 32'h2);
        chk("R11 head kept in tx", host_rdata, tx_word(99, 2));
        tx_collect(99, 8, 4, 8, 0);
        chk("R7 tx drain active", 32'({eng_active, data_end, tx_avail}), 32'h7);
        pop_chk("R1 leftover word", tx_word(99, 2));
        tick();
        chk("R7 tx drain idle", 32'(eng_active), 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule